// File: doc/BRIEF.md
# Bus Cycle Status Sequencer

This block is the processor-side state machine that paces each bus cycle through its clock states, T1, T2, T3, any number of wait states TW, then T4. It drives a 3-bit encoded status code that an external bus controller decodes into memory and I/O commands. The code for a cycle appears one clock before the cycle starts, in T4 of the previous cycle or in a lead-in T4 after idle. It goes back to the passive code in the clock in which READY is found high. The controller sees a cycle start only as a move away from the passive code and sees it end only as the return to it.

A requester holds `req_valid` high with `req_type` until it sees the cycle reach T1. An arbiter can ask for the bus with `float_req`. The block then stops at the next cycle boundary, releases the status lines by dropping the output enable, and presents the passive level while the bus is granted. The reset input is asserted asynchronously and released through a synchronizer.

Top module: `bus_status_seq`

## Requirements
- R1: While `rst_in` is high, `seq_state` is IDLE (code 0), `stat_val` is 111 and `stat_oe` is 1. This takes effect at once, without waiting for a clock edge.
- R2: Release of reset is synchronized. After `rst_in` falls, the state stays IDLE at the first and second rising edges. It can leave IDLE no earlier than the third rising edge (with SYNC_STAGES = 2).
- R3: `seq_state` codes are IDLE=0, T1=1, T2=2, T3=3, TW=4, T4=5, FLOAT=6. A cycle always runs T1, T2, T3, then zero or more TW, then T4.
- R4: READY is sampled at the rising edge that ends T3 and at the edge that ends each TW. While it is low, another TW follows. When it is high, T4 follows. A cycle therefore holds one TW for each edge at which READY is low.
- R5: Status codes: 000 interrupt acknowledge, 001 I/O read, 010 I/O write, 011 halt, 100 code fetch, 101 memory read, 110 memory write, 111 passive. A cycle's code is driven in the T4 before it, in T1 and T2, and in T3 or TW while READY is low.
- R6: `stat_val` is 111 during the T3 or TW in which READY is high.
- R7: If `req_valid` is high at the edge ending the last T3/TW, T4 carries the new code and T1 follows directly. The controller sees passive and then the new code.
- R8: With no request at the end of a cycle, T4 shows passive and the sequencer moves to IDLE. A request seen in IDLE gives T4 with its code at the next edge, then T1.
- R9: `float_req` high in IDLE, or at the end of a cycle's last T3/TW, leads to FLOAT. The route from the end of a cycle is through a passive T4 in which no request is taken. In FLOAT, `stat_oe` is 0 and `stat_val` is 111.
- R10: When `float_req` drops in FLOAT, the sequencer returns to IDLE for at least one clock before any new cycle's T4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_in | input | 1 | Reset, active high, asserted asynchronously |
| req_valid | input | 1 | A bus cycle is requested |
| req_type | input | 3 | Status code of the requested cycle |
| ready | input | 1 | Slave ready, sampled at the end of T3/TW |
| float_req | input | 1 | Arbiter asks to take the bus |
| stat_val | output | 3 | Encoded status value |
| stat_oe | output | 1 | Status driver enable, 0 while floated |
| seq_state | output | 3 | Current clock state code |

## Verification
The hardest case to reach from the ports is a float request that arrives at the end of a cycle while another request is already held pending. In that case the sequencer must pass over the waiting request, show a passive T4, float, idle for a clock and only then present the deferred code. The bench builds this case by raising both `float_req` and the next request during T1 of a cycle that has a wait state. It then follows the exact state sequence until the deferred cycle reaches T1. A reset asserted in the middle of a cycle, followed by a request held across the release, covers the immediate abort and the synchronizer latency.

// File: rtl/bss_pkg.sv
package bss_pkg;
   localparam int CODE_W = 3;
   localparam int STATE_W = 3;
   localparam logic [CODE_W-1:0] CODE_PASSIVE = '1;

   typedef enum logic [STATE_W-1:0] {
      ST_IDLE  = 3'd0,
      ST_T1    = 3'd1,
      ST_T2    = 3'd2,
      ST_T3    = 3'd3,
      ST_TW    = 3'd4,
      ST_T4    = 3'd5,
      ST_FLOAT = 3'd6
   } bss_state_e;
endpackage

// File: rtl/bss_rst_sync.sv
module bss_rst_sync #(
   parameter int STAGES = 2,
   parameter bit ASYNC_ASSERT = 1'b1
) (
   input  logic clk,
   input  logic rst_in,
   output logic rst_s
);
   logic [STAGES-1:0] sh;

   generate
      if (STAGES < 2) begin : g_bad
         $error("bss_rst_sync: STAGES must be at least 2");
      end
      if (ASYNC_ASSERT) begin : g_async
         always_ff @(posedge clk or posedge rst_in) begin
            if (rst_in) sh <= '1;
            else        sh <= {sh[STAGES-2:0], 1'b0};
         end
      end else begin : g_sync
         always_ff @(posedge clk) begin
            if (rst_in) sh <= '1;
            else        sh <= {sh[STAGES-2:0], 1'b0};
         end
      end
   endgenerate

   assign rst_s = sh[STAGES-1];
endmodule

// File: rtl/bss_fsm.sv
module bss_fsm
   import bss_pkg::*;
(
   input  logic              clk,
   input  logic              rst_s,
   input  logic              req_valid,
   input  logic [CODE_W-1:0] req_type,
   input  logic              ready,
   input  logic              float_req,
   output bss_state_e        state,
   output logic [CODE_W-1:0] cyc_type,
   output logic              pend
);
   bss_state_e        nxt_state;
   logic              nxt_pend;
   logic [CODE_W-1:0] nxt_type;

   always_comb begin
      nxt_state = state;
      nxt_pend  = pend;
      nxt_type  = cyc_type;
      unique case (state)
         ST_IDLE: begin
            if (float_req) begin
               nxt_state = ST_FLOAT;
            end else if (req_valid) begin
               nxt_state = ST_T4;
               nxt_pend  = 1'b1;
               nxt_type  = req_type;
            end
         end
         ST_T1: nxt_state = ST_T2;
         ST_T2: nxt_state = ST_T3;
         ST_T3, ST_TW: begin
            if (!ready) begin
               nxt_state = ST_TW;
            end else begin
               nxt_state = ST_T4;
               nxt_pend  = req_valid && !float_req;
               if (req_valid && !float_req) nxt_type = req_type;
            end
         end
         ST_T4: begin
            if (pend) begin
               nxt_state = ST_T1;
               nxt_pend  = 1'b0;
            end else if (float_req) begin
               nxt_state = ST_FLOAT;
            end else begin
               nxt_state = ST_IDLE;
            end
         end
         ST_FLOAT: if (!float_req) nxt_state = ST_IDLE;
         default: nxt_state = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or posedge rst_s) begin
      if (rst_s) begin
         state    <= ST_IDLE;
         pend     <= 1'b0;
         cyc_type <= CODE_PASSIVE;
      end else begin
         state    <= nxt_state;
         pend     <= nxt_pend;
         cyc_type <= nxt_type;
      end
   end

   // R4
   wait_insert_chk: assert property (@(posedge clk) disable iff (rst_s)
      ((state == ST_T3 || state == ST_TW) && !ready) |=> state == ST_TW);

   // R3
   t1_entry_chk: assert property (@(posedge clk) disable iff (rst_s)
      state == ST_T1 |-> $past(state) == ST_T4);

   // R10
   float_exit_chk: assert property (@(posedge clk) disable iff (rst_s)
      (state == ST_FLOAT && !float_req) |=> state == ST_IDLE);

   // R5
   type_hold_chk: assert property (@(posedge clk) disable iff (rst_s)
      (state == ST_T2 || state == ST_T3 || state == ST_TW) |-> $stable(cyc_type));
endmodule

// File: rtl/bss_status_enc.sv
module bss_status_enc
   import bss_pkg::*;
(
   input  bss_state_e        state,
   input  logic              pend,
   input  logic [CODE_W-1:0] cyc_type,
   input  logic              ready,
   output logic [CODE_W-1:0] stat_val,
   output logic              stat_oe
);
   always_comb begin
      stat_oe  = 1'b1;
      stat_val = CODE_PASSIVE;
      unique case (state)
         ST_T4:        stat_val = pend ? cyc_type : CODE_PASSIVE;
         ST_T1, ST_T2: stat_val = cyc_type;
         ST_T3, ST_TW: stat_val = ready ? CODE_PASSIVE : cyc_type;
         ST_FLOAT:     stat_oe  = 1'b0;
         default:      stat_val = CODE_PASSIVE;
      endcase
   end
endmodule

// File: rtl/bus_status_seq.sv
module bus_status_seq
   import bss_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter bit ASYNC_ASSERT = 1'b1
) (
   input  logic         clk,
   input  logic         rst_in,
   input  logic         req_valid,
   input  logic [2:0]   req_type,
   input  logic         ready,
   input  logic         float_req,
   output logic [2:0]   stat_val,
   output logic         stat_oe,
   output logic [2:0]   seq_state
);
   logic              rst_s;
   bss_state_e        state;
   logic [CODE_W-1:0] cyc_type;
   logic              pend;

   bss_rst_sync #(.STAGES(SYNC_STAGES), .ASYNC_ASSERT(ASYNC_ASSERT)) u_sync (
      .clk(clk), .rst_in(rst_in), .rst_s(rst_s)
   );

   bss_fsm u_fsm (
      .clk(clk), .rst_s(rst_s), .req_valid(req_valid), .req_type(req_type),
      .ready(ready), .float_req(float_req), .state(state),
      .cyc_type(cyc_type), .pend(pend)
   );

   bss_status_enc u_enc (
      .state(state), .pend(pend), .cyc_type(cyc_type), .ready(ready),
      .stat_val(stat_val), .stat_oe(stat_oe)
   );

   assign seq_state = state;

   // R9
   float_passive_chk: assert property (@(posedge clk) disable iff (rst_s)
      !stat_oe |-> (stat_val == CODE_PASSIVE && state == ST_FLOAT));

   // R6
   t4_lead_chk: assert property (@(posedge clk) disable iff (rst_s)
      state == ST_T4 |-> $past(stat_val) == CODE_PASSIVE);
endmodule

// File: tb/sim_bus_status_seq.sv
module sim_bus_status_seq;
   localparam int CLK_P = 10;
   localparam logic [2:0] PAS = 3'b111;
   localparam logic [2:0] S_IDLE = 3'd0, S_T1 = 3'd1, S_T2 = 3'd2, S_T3 = 3'd3,
                          S_TW = 3'd4, S_T4 = 3'd5, S_FLT = 3'd6;

   logic clk = 1'b0;
   logic rst_in = 1'b1;
   logic req_valid = 1'b0;
   logic [2:0] req_type = 3'd0;
   logic ready = 1'b0;
   logic float_req = 1'b0;
   logic [2:0] stat_val;
   logic stat_oe;
   logic [2:0] seq_state;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   typedef struct { logic [2:0] code; int waits; } exp_t;
   exp_t sb_q[$];

   bus_status_seq u0 (
      .clk(clk), .rst_in(rst_in), .req_valid(req_valid), .req_type(req_type),
      .ready(ready), .float_req(float_req), .stat_val(stat_val),
      .stat_oe(stat_oe), .seq_state(seq_state)
   );

   always #(CLK_P/2) clk = ~clk;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   // Scoreboard monitor: cycle start is the move away from passive, end is the return.
   logic [2:0] prev_val = PAS;
   bit in_cyc = 1'b0;
   int tw_cnt = 0;
   exp_t cur;
   always begin
      @(negedge clk);
      #(CLK_P/4);
      if (rst_in) begin
         in_cyc = 1'b0;
         prev_val = PAS;
      end else begin
         chk(stat_oe == (seq_state != S_FLT), "R9 oe", stat_oe, seq_state != S_FLT);
         if (stat_oe && stat_val != PAS && prev_val == PAS) begin
            if (sb_q.size() == 0) begin
               chk(1'b0, "R5 unexpected cycle start", stat_val, PAS);
            end else begin
               cur = sb_q.pop_front();
               chk(stat_val == cur.code, "R5 start code", stat_val, cur.code);
            end
            in_cyc = 1'b1;
            tw_cnt = 0;
         end else if (in_cyc) begin
            if (seq_state == S_TW) tw_cnt++;
            if (stat_val == PAS) begin
               chk(tw_cnt == cur.waits, "R4 wait states", tw_cnt, cur.waits);
               in_cyc = 1'b0;
            end
         end
         prev_val = stat_val;
      end
   end

   // Driver: one cycle from request to its final T3/TW.
   task automatic do_cycle(input logic [2:0] code, input int waits,
                           input bit has_next, input logic [2:0] nxt, input bit flt);
      exp_t e;
      e.code = code;
      e.waits = waits;
      sb_q.push_back(e);
      req_valid = 1'b1;
      req_type = code;
      do begin
         @(negedge clk);
         if (seq_state == S_T4)
            chk(stat_val == code, "R5 code in T4", stat_val, code);
      end while (seq_state != S_T1);
      chk(stat_val == code, "R5 code in T1", stat_val, code);
      req_valid = has_next;
      req_type = nxt;
      float_req = flt;
      @(negedge clk);
      chk(seq_state == S_T2, "R3 T2", seq_state, S_T2);
      chk(stat_val == code, "R5 code in T2", stat_val, code);
      @(negedge clk);
      chk(seq_state == S_T3, "R3 T3", seq_state, S_T3);
      ready = (waits == 0);
      #1;
      chk(stat_val == ((waits == 0) ? PAS : code), "R6 T3 status", stat_val,
          (waits == 0) ? PAS : code);
      for (int i = 1; i <= waits; i++) begin
         @(negedge clk);
         chk(seq_state == S_TW, "R4 TW", seq_state, S_TW);
         ready = (i == waits);
         #1;
         chk(stat_val == ((i == waits) ? PAS : code), "R6 TW status", stat_val,
             (i == waits) ? PAS : code);
      end
   endtask

   initial begin
      #(CLK_P * 100000);
      chk(1'b0, "watchdog", 0, 1);
      finish_run();
   end

   initial begin
      #(CLK_P/4);
      chk(seq_state == S_IDLE, "R1 reset state", seq_state, S_IDLE);
      chk(stat_val == PAS, "R1 reset status", stat_val, PAS);
      chk(stat_oe == 1'b1, "R1 reset oe", stat_oe, 1);
      repeat (5) @(negedge clk);
      rst_in = 1'b0;
      repeat (3) @(negedge clk);

      // R8: request from idle, no follow-on
      do_cycle(3'b101, 0, 1'b0, 3'b000, 1'b0);
      @(negedge clk);
      chk(seq_state == S_T4 && stat_val == PAS, "R8 passive T4", stat_val, PAS);
      @(negedge clk);
      chk(seq_state == S_IDLE, "R8 idle", seq_state, S_IDLE);
      @(negedge clk);

      // R7: back-to-back chain with various waits
      do_cycle(3'b010, 2, 1'b1, 3'b100, 1'b0);
      do_cycle(3'b100, 0, 1'b1, 3'b011, 1'b0);
      do_cycle(3'b011, 1, 1'b1, 3'b000, 1'b0);
      do_cycle(3'b000, 3, 1'b1, 3'b001, 1'b0);
      do_cycle(3'b001, 0, 1'b1, 3'b110, 1'b0);
      do_cycle(3'b110, 0, 1'b0, 3'b000, 1'b0);
      @(negedge clk);
      chk(seq_state == S_T4 && stat_val == PAS, "R8 passive T4 after chain", stat_val, PAS);
      @(negedge clk);

      // R9/R10: float from idle
      float_req = 1'b1;
      @(negedge clk);
      chk(seq_state == S_FLT, "R9 float from idle", seq_state, S_FLT);
      chk(stat_oe == 1'b0 && stat_val == PAS, "R9 float lines", stat_oe, 0);
      float_req = 1'b0;
      @(negedge clk);
      chk(seq_state == S_IDLE, "R10 idle after float", seq_state, S_IDLE);

      // R9: float at end of cycle with a request pending
      do_cycle(3'b010, 1, 1'b1, 3'b101, 1'b1);
      @(negedge clk);
      chk(seq_state == S_T4, "R9 T4 before float", seq_state, S_T4);
      chk(stat_val == PAS, "R9 pending not taken", stat_val, PAS);
      @(negedge clk);
      chk(seq_state == S_FLT && !stat_oe, "R9 floated", seq_state, S_FLT);
      @(negedge clk);
      chk(seq_state == S_FLT && stat_val == PAS, "R9 held float", seq_state, S_FLT);
      float_req = 1'b0;
      @(negedge clk);
      chk(seq_state == S_IDLE, "R10 idle clock", seq_state, S_IDLE);
      do_cycle(3'b101, 0, 1'b0, 3'b000, 1'b0);
      repeat (3) @(negedge clk);

      // R1: reset in mid-cycle
      sb_q.push_back('{code: 3'b101, waits: 0});
      req_valid = 1'b1;
      req_type = 3'b101;
      do @(negedge clk); while (seq_state != S_T2);
      rst_in = 1'b1;
      req_valid = 1'b0;
      #1;
      chk(seq_state == S_IDLE, "R1 abort state", seq_state, S_IDLE);
      chk(stat_val == PAS && stat_oe, "R1 abort status", stat_val, PAS);
      repeat (4) @(negedge clk);

      // R2: synchronized release with a request already held
      rst_in = 1'b0;
      req_valid = 1'b1;
      req_type = 3'b001;
      @(negedge clk);
      chk(seq_state == S_IDLE, "R2 edge 1", seq_state, S_IDLE);
      do_cycle(3'b001, 1, 1'b0, 3'b000, 1'b0);
      repeat (3) @(negedge clk);
      chk(sb_q.size() == 0, "R5 scoreboard drained", sb_q.size(), 0);
      finish_run();
   end

   // R2: the second edge after release must still show IDLE
   initial begin
      @(negedge rst_in);
      @(negedge rst_in);
      repeat (2) @(negedge clk);
      #1;
      chk(seq_state == S_IDLE, "R2 edge 2", seq_state, S_IDLE);
      @(negedge clk);
      #1;
      chk(seq_state == S_T4, "R2 edge 3", seq_state, S_T4);
   end
endmodule